// File: doc/BRIEF.md
# Two-Pair Serial Pattern Detector

This block watches a one-bit serial input and reports, on a single Moore output, that two events have both happened since it was last initialised. One event is the input sampled low on two consecutive clocks. The other is the input sampled high on two consecutive clocks. The two events may arrive in either order, and consecutive runs may share no bits or touch each other.

Once both events have been seen, the output goes high. It stays high whatever the serial input does, until the synchronous initialise input is asserted again. While initialise is held, the machine stays in its idle state with the output low. The idle state has no remembered previous bit and no event recorded.

The control part keeps the phase (idle, watching, latched) and issues strobes. The datapath part keeps the last sampled bit, the length of the current run and the two event flags. The run length that counts as an event is a parameter with a default of two.

Top module: `pairdet`

## Requirements
- R1: When initIn is sampled high at a rising clock edge, zOut is 0 after that edge, and it stays 0 on every clock while initIn remains high.
- R2: After initIn is released, zOut stays 0 until both a low pair and a high pair have been sampled on xIn.
- R3: The sequence 0,0 followed later by 1,1 drives zOut to 1 right after the edge that samples the second 1.
- R4: The order 1,1 followed later by 0,0 also drives zOut to 1, right after the edge that samples the second 0.
- R5: Runs that touch count as separate events: the sequence 0,0,1,1 straight after release sets zOut after the fourth bit.
- R6: A run of three or more equal bits counts only as that one event. For example, 0,0,0 never sets zOut without a later 1,1.
- R7: Once zOut is 1, it stays 1 for any xIn values while initIn stays low.
- R8: A pulse on initIn in the middle of a sequence erases both event flags and the remembered bit. Bits sampled before the pulse never help to complete a pair.
- R9: zOut is a Moore output. It changes only at rising clock edges, and a change on xIn between edges has no effect on it.
- R10: The first bit sampled after initIn is released cannot complete a pair on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| initIn | input | 1 | Synchronous initialise, active high |
| xIn | input | 1 | Serial data bit, sampled on each rising edge |
| zOut | output | 1 | High once both pairs have been seen since the last initialise |

## Verification
Each result comes from a single register stage. The bit or initialise value sampled at one rising edge shows up on zOut right after that same edge. The bench drives inputs on the falling edge, updates its model at the rising edge, and compares one time unit later. It then flips xIn between edges and compares again, to confirm that zOut does not follow the input. The directed sequences cover both pair orders, touching pairs, long runs, initialise pulses in the middle of a sequence and initialise while latched. Long random runs follow, with occasional initialise pulses.

// File: rtl/pairdet_pkg.sv
package pairdet_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WATCH = 2'd1,
    PH_LATCH = 2'd2
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic capturePrev;
    logic markLow;
    logic markHigh;
  } dpStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic lowPairNow;
    logic highPairNow;
    logic lowSeen;
    logic highSeen;
  } dpStatus_t;

endpackage

// File: rtl/pairdet_datapath.sv
module pairdet_datapath
  import pairdet_pkg::*;
#(
  parameter int RUN_LEN = 2
) (
  input  logic      clk,
  input  logic      xIn,
  input  dpStrobe_t strobe,
  output dpStatus_t status
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

  logic             prevBit;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             lowSeen;
  logic             highSeen;

  // Length of the run that includes the bit being sampled now
  always_comb begin
    if (runCnt != '0 && xIn == prevBit) begin
      nextCnt = (runCnt == RUN_MAX) ? RUN_MAX : runCnt + RUN_ONE;
    end else begin
      nextCnt = RUN_ONE;
    end
  end

  always_comb begin
    status.lowPairNow  = (nextCnt == RUN_MAX) && !xIn;
    status.highPairNow = (nextCnt == RUN_MAX) && xIn;
    status.lowSeen     = lowSeen;
    status.highSeen    = highSeen;
  end

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      prevBit  <= 1'b0;
      runCnt   <= '0;
      lowSeen  <= 1'b0;
      highSeen <= 1'b0;
    end else begin
      if (strobe.capturePrev) begin
        prevBit <= xIn;
        runCnt  <= nextCnt;
      end
      if (strobe.markLow)  lowSeen  <= 1'b1;
      if (strobe.markHigh) highSeen <= 1'b1;
    end
  end

  AST_LOW_FLAG_STICKS: assert property (@(posedge clk) disable iff (strobe.clearAll)
    lowSeen |=> lowSeen); // R2
  AST_HIGH_FLAG_STICKS: assert property (@(posedge clk) disable iff (strobe.clearAll)
    highSeen |=> highSeen); // R2
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (strobe.clearAll)
    runCnt <= RUN_MAX); // R6
  AST_CLEAR_EMPTIES_RUN: assert property (@(posedge clk)
    strobe.clearAll |=> (runCnt == '0 && !lowSeen && !highSeen)); // R8

endmodule

// File: rtl/pairdet_ctrl.sv
module pairdet_ctrl
  import pairdet_pkg::*;
(
  input  logic      clk,
  input  logic      initIn,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      zOut
);

  phase_e phase;
  phase_e phaseNext;
  logic   bothNext;
  logic   active;

  assign bothNext = (status.lowSeen  || status.lowPairNow) &&
                    (status.highSeen || status.highPairNow);
  assign active   = !initIn && (phase != PH_LATCH);

  always_comb begin
    strobe.clearAll    = initIn;
    strobe.capturePrev = active;
    strobe.markLow     = active && status.lowPairNow;
    strobe.markHigh    = active && status.highPairNow;
  end

  always_comb begin
    phaseNext = phase;
    if (initIn) begin
      phaseNext = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:  phaseNext = bothNext ? PH_LATCH : PH_WATCH;
        PH_WATCH: phaseNext = bothNext ? PH_LATCH : PH_WATCH;
        PH_LATCH: phaseNext = PH_LATCH;
        default:  phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    phase <= phaseNext;
  end

  assign zOut = (phase == PH_LATCH);

  AST_INIT_FORCES_IDLE: assert property (@(posedge clk)
    initIn |=> (phase == PH_IDLE)); // R1
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (initIn)
    (phase == PH_LATCH) |=> (phase == PH_LATCH)); // R7
  AST_IDLE_LEAVES: assert property (@(posedge clk) disable iff (initIn)
    (phase == PH_IDLE) |=> (phase == PH_WATCH)); // R10

endmodule

// File: rtl/pairdet.sv
module pairdet
  import pairdet_pkg::*;
#(
  parameter int RUN_LEN = 2
) (
  input  logic clk,
  input  logic initIn,
  input  logic xIn,
  output logic zOut
);

  dpStrobe_t strobe;
  dpStatus_t status;

  pairdet_ctrl ctrl_i (
    .clk    (clk),
    .initIn (initIn),
    .status (status),
    .strobe (strobe),
    .zOut   (zOut)
  );

  pairdet_datapath #(.RUN_LEN(RUN_LEN)) dp_i (
    .clk    (clk),
    .xIn    (xIn),
    .strobe (strobe),
    .status (status)
  );

  AST_Z_NEEDS_BOTH: assert property (@(posedge clk) disable iff (initIn)
    zOut |-> (status.lowSeen && status.highSeen)); // R2
  AST_Z_RISES_ON_PAIR: assert property (@(posedge clk) disable iff (initIn)
    $rose(zOut) |-> $past(status.lowPairNow || status.highPairNow)); // R3

endmodule

// File: tb/pairdet_tb_top.sv
`timescale 1ns/1ps
module pairdet_tb_top;

  logic clk = 1'b0;
  logic initIn = 1'b1;
  logic xIn = 1'b0;
  logic zOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference state, written from the requirements
  bit mPrevValid, mPrev, mLow, mHigh, mZ;
  int mRun;

  always #2 clk = ~clk;

  pairdet dut_i (.clk(clk), .initIn(initIn), .xIn(xIn), .zOut(zOut));

  function automatic void modelStep(input bit i, input bit x);
    if (i) begin
      mPrevValid = 0; mPrev = 0; mRun = 0; mLow = 0; mHigh = 0; mZ = 0;
    end else if (!mZ) begin
      mRun = (mPrevValid && x == mPrev) ? ((mRun >= 2) ? 2 : mRun + 1) : 1;
      if (mRun == 2 && !x) mLow = 1;
      if (mRun == 2 && x)  mHigh = 1;
      mPrev = x; mPrevValid = 1;
      if (mLow && mHigh) mZ = 1;
    end
  endfunction

  task automatic checkZ(input bit exp, input string tag);
    checks++;
    if (zOut !== exp) begin
      errors++;
      $display("FAIL %s: zOut=%b expected=%b at %0t", tag, zOut, exp, $time);
    end
  endtask

  task automatic step(input bit i, input bit x, input string tag);
    @(negedge clk);
    initIn = i; xIn = x;
    @(posedge clk);
    modelStep(i, x);
    #1;
    checkZ(mZ, tag);
    xIn = ~x;       // R9: mid-cycle input change
    #0.5;
    checkZ(mZ, "R9");
  endtask

  task automatic seq4(input bit a, input bit b, input bit c, input bit d, input string tag);
    step(0, a, tag); step(0, b, tag); step(0, c, tag); step(0, d, tag);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240607);
    // R1: held in initialise
    for (int k = 0; k < 3; k++) step(1, k[0], "R1");
    checkZ(1'b0, "R1");
    // R10: first bit after release
    step(0, 0, "R10");
    checkZ(1'b0, "R10");
    // R5 and R3: touching pairs 0,0,1,1 (first 0 already sampled)
    step(0, 0, "R5"); step(0, 1, "R5");
    checkZ(1'b0, "R2");
    step(0, 1, "R3");
    checkZ(1'b1, "R3");
    // R7: sticky under arbitrary input
    for (int k = 0; k < 8; k++) step(0, (k % 3) == 0, "R7");
    checkZ(1'b1, "R7");
    // R1: initialise while latched
    step(1, 1, "R1");
    checkZ(1'b0, "R1");
    // R4: 1,1 then 0,0 with gap
    seq4(1, 1, 0, 1, "R4");
    checkZ(1'b0, "R4");
    step(0, 0, "R4"); step(0, 0, "R4");
    checkZ(1'b1, "R4");
    // R6: long run of zeros
    step(1, 0, "R1");
    seq4(0, 0, 0, 0, "R6");
    step(0, 0, "R6");
    checkZ(1'b0, "R6");
    step(0, 1, "R6"); step(0, 1, "R6");
    checkZ(1'b1, "R6");
    // R8: initialise pulse mid-sequence
    step(1, 0, "R1");
    step(0, 0, "R8"); step(0, 0, "R8"); step(0, 1, "R8");
    step(1, 1, "R8");
    step(0, 1, "R8");
    checkZ(1'b0, "R8");
    step(0, 1, "R8");
    checkZ(1'b0, "R8");
    step(0, 0, "R8"); step(0, 0, "R8");
    checkZ(1'b1, "R8");
    // Random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 24) == 0, $urandom % 2, "R2");
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #700000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule